// File: doc/BRIEF.md
# UART Modem Status Register

This block is the modem status register of one UART channel. It watches four active-low modem handshake inputs: carrier detect, ring indicator, data set ready and clear to send. The upper nibble of the register gives the present state of each line as an active-high status bit. The lower nibble holds one change flag per line. A flag stays set until the CPU reads the register. When any flag is set and the interrupt enable is high, a modem status interrupt request is raised.

The pins first cross into the clock domain through a synchronizer. A loopback mode then swaps each pin for one bit of the modem control register: data terminal ready, request to send, and the two general-purpose outputs. Change detection runs after this swap, so looped values raise flags exactly as pins do.

Each change flag is a small two-state machine. Its states are `DLT_CLEAR` (nothing pending) and `DLT_PENDING` (a change is latched). It has three transitions:
- *capture* (`DLT_CLEAR` to `DLT_PENDING`) fires on a qualifying edge.
- *acknowledge* (`DLT_PENDING` to `DLT_CLEAR`) fires on a read when no new edge occurs in that cycle.
- *retain* (`DLT_PENDING` stays) fires otherwise.

The ring line qualifies only on the pin's low-to-high edge. The other three lines qualify on either edge.

Top module: `mstat_reg`

## Requirements
- R1: After reset, `rd_data` is 0, every change flag is clear and `msi_irq` is 0. The sync flops reset to the idle (high) pin level.
- R2: In normal mode, the status bits are the complements of the pins: bit 7 = carrier, bit 6 = ring, bit 5 = data set ready, bit 4 = clear to send. A pin change reaches the status bits and flags on the third rising edge after it is applied.
- R3: In loopback mode, bit 7 takes `mctl[3]`, bit 6 takes `mctl[2]`, bit 5 takes `mctl[0]` and bit 4 takes `mctl[1]`. These values are not inverted, and they appear one edge after they are applied.
- R4: Flags in bits 3, 1 and 0 (carrier, data set ready, clear to send) set on any change of their line, in either direction.
- R5: The ring flag (bit 2) sets only when the ring pin goes from 0 to 1, which is a fall of status bit 6. The opposite change leaves the flag clear.
- R6: A read (`rd_en` high at a rising edge) loads `rd_data` with the status and flags as they were before that edge. The same edge clears bits 3:0. Flags that are not read stay set.
- R7: If a qualifying change and a read fall on the same edge, that line's flag is still set after the read.
- R8: `msi_irq` is combinationally `msi_en` AND the OR of the four flags.
- R9: In loopback mode the external pins have no effect on the status bits or the flags. Entering or leaving loopback sets a flag only on lines whose value differs between the two sources.
- R10: When `rd_en` is low, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data: status in [7:4], change flags in [3:0] |
| carrier_n | input | 1 | Carrier detect pin, active low |
| ring_n | input | 1 | Ring indicator pin, active low |
| dset_n | input | 1 | Data set ready pin, active low |
| csend_n | input | 1 | Clear to send pin, active low |
| mctl | input | 4 | Modem control bits: [0] terminal ready, [1] request to send, [2] output 1, [3] output 2 |
| loop_en | input | 1 | Loopback mode enable |
| msi_en | input | 1 | Modem status interrupt enable |
| msi_irq | output | 1 | Modem status interrupt request |

## Verification
A qualifying edge and a read strobe can land on the same rising edge. In that cycle the *capture* and *acknowledge* transitions compete. The bench provokes this in loopback: it changes a modem control bit in the same half-cycle it raises `rd_en`. It then judges that the returned byte holds the pre-change status with no flag, and that the interrupt stays asserted afterwards. A second read must then show the flag, and a third read must show it cleared.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int LINES   = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_CD  = 3;

    typedef enum logic {
        DLT_CLEAR   = 1'b0,
        DLT_PENDING = 1'b1
    } delta_state_t;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_t;

    // Modem control bit that replaces a line in loopback mode.
    function automatic int loop_src(input int line);
        case (line)
            IDX_CTS: return 1;
            IDX_DSR: return 0;
            IDX_RI:  return 2;
            default: return 3;
        endcase
    endfunction

    // Ring only flags a falling status level (pin low to high).
    function automatic edge_kind_t line_edge(input int line);
        return (line == IDX_RI) ? EDGE_FALL : EDGE_ANY;
    endfunction

endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
    parameter int   W       = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= {W{RST_VAL}};
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/mstat_delta.sv
module mstat_delta
    import mstat_pkg::*;
#(
    parameter edge_kind_t KIND = EDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic ack_i,
    output logic level_o,
    output logic pending_o
);
    logic         level_q;
    logic         hit;
    delta_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    if (KIND == EDGE_FALL) begin : g_fall
        assign hit = level_q & ~level_i;
        // R5: a flag rise must come from a high-to-low level step
        assert_fall_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending_o) |-> ($past(level_q) && !$past(level_i)));
    end else begin : g_any
        assign hit = level_q ^ level_i;
        assert_any_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (level_i != level_q) |=> pending_o);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DLT_CLEAR;
        else        state_q <= state_d;
    end

    // Transitions: capture, acknowledge, retain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLT_CLEAR:   if (hit)            state_d = DLT_PENDING;
            DLT_PENDING: if (ack_i && !hit)  state_d = DLT_CLEAR;
            default:                         state_d = DLT_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        pending_o = (state_q == DLT_PENDING);
        level_o   = level_q;
    end

    assert_retain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ack_i) |=> pending_o);
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit) |=> !pending_o);

endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
    import mstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       carrier_n,
    input  logic       ring_n,
    input  logic       dset_n,
    input  logic       csend_n,
    input  logic [3:0] mctl,
    input  logic       loop_en,
    input  logic       msi_en,
    output logic       msi_irq
);
    logic [LINES-1:0] pins_raw;
    logic [LINES-1:0] pins_s;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] held;
    logic [LINES-1:0] pend;

    always_comb begin
        pins_raw[IDX_CD]  = carrier_n;
        pins_raw[IDX_RI]  = ring_n;
        pins_raw[IDX_DSR] = dset_n;
        pins_raw[IDX_CTS] = csend_n;
    end

    mstat_sync #(
        .W       (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam int         SRC  = loop_src(i);
        localparam edge_kind_t KIND = line_edge(i);

        assign lvl[i] = loop_en ? mctl[SRC] : ~pins_s[i];

        mstat_delta #(.KIND(KIND)) u_delta (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_i   (lvl[i]),
            .ack_i     (rd_en),
            .level_o   (held[i]),
            .pending_o (pend[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= {held, pend};
    end

    assign msi_irq = msi_en & (|pend);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> !msi_irq);
    assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_en) |-> (held == {$past(mctl[3]), $past(mctl[2]),
                                     $past(mctl[0]), $past(mctl[1])}));

endmodule

// File: tb/mstat_reg_tb.sv
module mstat_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       carrier_n = 1'b1, ring_n = 1'b1, dset_n = 1'b1, csend_n = 1'b1;
    logic [3:0] mctl = 4'h0;
    logic       loop_en = 1'b0;
    logic       msi_en = 1'b1;
    logic       msi_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mstat_reg u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .carrier_n(carrier_n), .ring_n(ring_n), .dset_n(dset_n), .csend_n(csend_n),
        .mctl(mctl), .loop_en(loop_en), .msi_en(msi_en), .msi_irq(msi_irq)
    );

    // {loop, mctl[3:0], pins {cd,ri,dsr,cts}, expected status {cd,ri,dsr,cts}}
    localparam logic [12:0] VEC [10] = '{
        13'b0_0000_1111_0000,
        13'b0_0000_0111_1000,
        13'b0_0000_0011_1100,
        13'b0_0000_0111_1000,
        13'b0_0000_1100_0011,
        13'b0_0000_1111_0000,
        13'b1_1010_1111_1001,
        13'b1_0101_0000_0110,
        13'b1_0001_0000_0010,
        13'b0_0001_0000_1111
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] val);
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic set_pins(input logic [3:0] p);
        {carrier_n, ring_n, dset_n, csend_n} = p;
    endtask

    initial begin
        logic [7:0] rv;
        logic [3:0] prev_hi;
        logic [3:0] exp_d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 irq", {7'd0, msi_irq}, 8'h00);
        do_read(rv);
        check("R1 first read", rv, 8'h00);

        // Table walk: R2, R3, R4, R5, R6, R8, R9
        prev_hi = 4'b0000;
        for (int k = 0; k < 10; k++) begin
            loop_en = VEC[k][12];
            mctl    = VEC[k][11:8];
            set_pins(VEC[k][7:4]);
            repeat (4) step();
            exp_d = ((prev_hi ^ VEC[k][3:0]) & 4'b1011) |
                    (prev_hi & ~VEC[k][3:0] & 4'b0100);
            check($sformatf("R8 irq vec %0d", k), {7'd0, msi_irq}, {7'd0, |exp_d});
            do_read(rv);
            check($sformatf("R2/R3/R4/R5 vec %0d", k), rv, {VEC[k][3:0], exp_d});
            prev_hi = VEC[k][3:0];
        end

        // State now: normal mode, pins all low, status 1111, flags clear.
        // R2: latency of three edges
        csend_n = 1'b1;
        step(); step();
        check("R2 latency early", {7'd0, msi_irq}, 8'h00);
        step();
        check("R2 latency on time", {7'd0, msi_irq}, 8'h01);
        do_read(rv);
        check("R4 cts rise", rv, 8'b1110_0001);

        // R10: no read, data holds
        carrier_n = 1'b1;
        repeat (4) step();
        check("R10 hold", rd_data, 8'b1110_0001);

        // R8: gating
        msi_en = 1'b0;
        #1;
        check("R8 gated", {7'd0, msi_irq}, 8'h00);
        msi_en = 1'b1;
        #1;
        check("R8 enabled", {7'd0, msi_irq}, 8'h01);
        do_read(rv);
        check("R4 cd fall", rv, 8'b0110_1000);

        // R9: enter loopback with matching values, then wiggle pins
        mctl = 4'b0101;
        loop_en = 1'b1;
        repeat (4) step();
        check("R9 matched entry", {7'd0, msi_irq}, 8'h00);
        set_pins(4'b0110);
        repeat (4) step();
        check("R9 pins ignored irq", {7'd0, msi_irq}, 8'h00);
        do_read(rv);
        check("R9 pins ignored data", rv, 8'b0110_0000);

        // R7: change and read on the same edge
        mctl = 4'b1101;
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        check("R7 read data", rd_data, 8'b0110_0000);
        check("R7 flag kept irq", {7'd0, msi_irq}, 8'h01);
        do_read(rv);
        check("R7 flag visible", rv, 8'b1110_1000);
        do_read(rv);
        check("R6 cleared", rv, 8'b1110_0000);
        check("R6 irq low", {7'd0, msi_irq}, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule